// File: doc/BRIEF.md
# Step Pulse Generator with Timing Constraints

This block converts a signed rate word into motor step pulses on two output pins. A 32-bit phase accumulator adds the rate on every enabled clock. Each carry out of the top bit asks for one forward step, and each borrow asks for one reverse step. The requests are queued and issued only when the programmed timing allows it:

- the pulse width,
- the minimum gap between pulses,
- the direction setup time before a pulse,
- the direction hold time after a pulse.

All four times are counted in clocks.

Three pin formats are available: step plus direction, separate up and down pulses, and a two-bit Gray-code quadrature pattern. A signed counter of issued steps gives position feedback to the surrounding motion logic. Dropping enable stops all stepping at once, with no deceleration.

Top module: `step_pulse_gen`

## Requirements
- R1: After reset, pinA is 0, pinB is 1 (format 0 with direction forward), and stepCount is 0.
- R2: Each cycle with enable high, the unsigned 32-bit phase gains the signed rate. If rate >= 0, an unsigned carry out requests a forward step. If rate < 0, a borrow requests a reverse step. N enabled cycles at rate 2^30 (or -2^30) starting from phase 0 therefore request exactly N/4 steps.
- R3: In format 0 (step/dir) and format 1 (up/down), each step pulse is high for exactly stepLen clocks.
- R4: Between the fall of one step pulse and the rise of the next, the pulse pin stays low for at least stepSpace clocks.
- R5: In format 0, pinB is the direction (1 = forward). It is stable for at least dirSetup clocks before a pulse rises, and it stays constant while the pulse is high.
- R6: In format 0, pinB does not change until at least dirHold clocks after the previous pulse fell.
- R7: A timing word of zero acts as one clock.
- R8: In format 1, forward steps pulse pinA and reverse steps pulse pinB. The two pins are never high together.
- R9: In format 2, {pinA,pinB} runs 00→01→11→10→00 for each forward step and 00→10→11→01→00 for each reverse step. Each non-idle state lasts stepLen clocks, and only one pin changes per clock.
- R10: With enable low, the phase and the queued requests are cleared. Any active pulse ends so that the pins are idle from the next cycle, and no new steps are issued.
- R11: stepCount is signed. It changes by +1 or -1 in the cycle the step output starts, according to the step's direction.
- R12: Requests arriving faster than the timing allows are queued (up to 127 in one direction) and issued later, none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run; low stops stepping at once |
| rate | input | 32 | Signed phase increment per clock |
| stepLen | input | 16 | Step active time in clocks (per phase in format 2) |
| stepSpace | input | 16 | Minimum idle clocks between steps |
| dirSetup | input | 16 | Direction setup clocks before a step |
| dirHold | input | 16 | Direction hold clocks after a step |
| outFmt | input | 2 | 0 step/dir, 1 up/down, 2 quadrature, 3 as 0 |
| pinA | output | 1 | Step, up, or quadrature bit A |
| pinB | output | 1 | Direction, down, or quadrature bit B |
| stepCount | output | 32 | Signed count of issued steps |

## Verification
The bench runs the rate faster than the pulse period allows and checks two things. The count lags mid-run, and the final total is still exact. A design that dropped or duplicated queued requests would miss that total.

A mid-stream reversal with separate setup and hold values is watched by a pin monitor that measures every pulse width, gap and direction age. Swapped or missing setup and hold waits would show up there as a short direction age.

Zero timing words must still yield one-clock pulses rather than stuck or absent ones. The quadrature pattern is compared state by state in both directions, which catches an off-by-one phase or a reversed sequence. A pulse cut off by enable must leave the pins idle on the next cycle and the count frozen.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

  typedef enum logic [1:0] {
    FMT_STEPDIR = 2'd0,
    FMT_UPDOWN  = 2'd1,
    FMT_QUAD    = 2'd2,
    FMT_SPARE   = 2'd3
  } fmt_e;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic       startStep;
    logic       endStep;
    logic       flipDir;
    logic       active;
    logic [1:0] phase;
  } ctl_bus_t;

  // datapath conditions consumed by control
  typedef struct packed {
    logic pendNz;
    logic wantFwd;
    logic dirFwd;
    logic holdOk;
    logic spaceOk;
    logic setupOk;
  } dp_stat_t;

endpackage

// File: rtl/stepgen_ctrl.sv
module stepgen_ctrl
  import stepgen_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              quadMode,
  input  logic [TIME_W-1:0] effLen,
  input  dp_stat_t          stat,
  output ctl_bus_t          ctl
);

  localparam logic [1:0] LAST_QPH = 2'd2;

  logic              inStep;
  logic [1:0]        subPh;
  logic [TIME_W-1:0] timer;
  logic              advance;

  always_comb begin
    ctl           = '0;
    ctl.active    = inStep;
    ctl.phase     = subPh;
    advance       = 1'b0;
    if (!enable) begin
      ctl.endStep = inStep;
    end else if (inStep) begin
      if (timer == TIME_W'(1)) begin
        if (quadMode && subPh != LAST_QPH) advance = 1'b1;
        else                               ctl.endStep = 1'b1;
      end
    end else if (stat.pendNz) begin
      if (stat.wantFwd != stat.dirFwd) begin
        ctl.flipDir = stat.holdOk;
      end else begin
        ctl.startStep = stat.spaceOk && stat.setupOk;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inStep <= 1'b0;
      subPh  <= '0;
      timer  <= '0;
    end else if (ctl.startStep) begin
      inStep <= 1'b1;
      subPh  <= '0;
      timer  <= effLen;
    end else if (ctl.endStep) begin
      inStep <= 1'b0;
      subPh  <= '0;
      timer  <= '0;
    end else if (advance) begin
      subPh  <= subPh + 2'd1;
      timer  <= effLen;
    end else if (inStep) begin
      timer  <= timer - TIME_W'(1);
    end
  end

endmodule

// File: rtl/stepgen_dp.sv
module stepgen_dp
  import stepgen_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic signed [ACC_W-1:0] rate,
  input  logic [TIME_W-1:0]       stepLen,
  input  logic [TIME_W-1:0]       stepSpace,
  input  logic [TIME_W-1:0]       dirSetup,
  input  logic [TIME_W-1:0]       dirHold,
  input  logic [1:0]              outFmt,
  input  ctl_bus_t                ctl,
  output dp_stat_t                stat,
  output logic [TIME_W-1:0]       effLen,
  output logic                    pinA,
  output logic                    pinB,
  output logic signed [CNT_W-1:0] stepCount
);

  localparam int AGE_W = TIME_W + 1;
  localparam int PW2   = PEND_W + 2;
  localparam logic signed [PW2-1:0] P_HI = PW2'((1 << (PEND_W - 1)) - 1);
  localparam logic signed [PW2-1:0] P_LO = -P_HI;

  function automatic logic [AGE_W-1:0] effOf(input logic [TIME_W-1:0] w);
    return (w == '0) ? AGE_W'(1) : {1'b0, w};
  endfunction

  logic [ACC_W-1:0]         phaseAcc, phaseNext;
  logic                     fwdReq, revReq;
  logic signed [PEND_W-1:0] pending;
  logic signed [PW2-1:0]    pSum, pIn, pIssue;
  logic                     dirFwd;
  logic [AGE_W-1:0]         sinceEnd, sinceDir;
  fmt_e                     fmt;

  assign effLen = (stepLen == '0) ? TIME_W'(1) : stepLen;
  assign fmt    = fmt_e'(outFmt);

  // phase accumulator and request detection
  assign phaseNext = phaseAcc + rate;
  assign fwdReq    = enable && !rate[ACC_W-1] && (phaseNext < phaseAcc);
  assign revReq    = enable &&  rate[ACC_W-1] && (phaseNext > phaseAcc);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) phaseAcc <= '0;
    else                   phaseAcc <= phaseNext;
  end

  // request queue as a signed backlog
  always_comb begin
    pIn    = fwdReq ? PW2'(1) : (revReq ? '1 : '0);
    pIssue = ctl.startStep ? (dirFwd ? PW2'(1) : '1) : '0;
    pSum   = PW2'(pending) + pIn - pIssue;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)  pending <= '0;
    else if (pSum > P_HI)   pending <= PEND_W'(P_HI);
    else if (pSum < P_LO)   pending <= PEND_W'(P_LO);
    else                    pending <= PEND_W'(pSum);
  end

  // direction and timing ages
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirFwd   <= 1'b1;
      sinceEnd <= '1;
      sinceDir <= '1;
    end else begin
      if (ctl.flipDir) dirFwd <= !dirFwd;

      if (ctl.endStep)                     sinceEnd <= AGE_W'(1);
      else if (!ctl.active && sinceEnd != '1) sinceEnd <= sinceEnd + AGE_W'(1);

      if (ctl.flipDir)         sinceDir <= AGE_W'(1);
      else if (sinceDir != '1) sinceDir <= sinceDir + AGE_W'(1);
    end
  end

  always_comb begin
    stat.pendNz  = (pending != '0);
    stat.wantFwd = !pending[PEND_W-1];
    stat.dirFwd  = dirFwd;
    stat.holdOk  = sinceEnd >= effOf(dirHold);
    stat.spaceOk = sinceEnd >= effOf(stepSpace);
    stat.setupOk = sinceDir >= effOf(dirSetup);
  end

  // position feedback
  always_ff @(posedge clk) begin
    if (!rst_n)             stepCount <= '0;
    else if (ctl.startStep) stepCount <= dirFwd ? stepCount + CNT_W'(1)
                                                : stepCount - CNT_W'(1);
  end

  // pin encoding
  always_comb begin
    pinA = 1'b0;
    pinB = 1'b0;
    unique case (fmt)
      FMT_UPDOWN: begin
        pinA = ctl.active &&  dirFwd;
        pinB = ctl.active && !dirFwd;
      end
      FMT_QUAD: begin
        if (ctl.active) begin
          unique case (ctl.phase)
            2'd0:    {pinA, pinB} = dirFwd ? 2'b01 : 2'b10;
            2'd1:    {pinA, pinB} = 2'b11;
            default: {pinA, pinB} = dirFwd ? 2'b10 : 2'b01;
          endcase
        end
      end
      default: begin
        pinA = ctl.active;
        pinB = dirFwd;
      end
    endcase
  end

endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen
  import stepgen_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic signed [ACC_W-1:0] rate,
  input  logic [TIME_W-1:0]       stepLen,
  input  logic [TIME_W-1:0]       stepSpace,
  input  logic [TIME_W-1:0]       dirSetup,
  input  logic [TIME_W-1:0]       dirHold,
  input  logic [1:0]              outFmt,
  output logic                    pinA,
  output logic                    pinB,
  output logic signed [CNT_W-1:0] stepCount
);

  ctl_bus_t          ctl;
  dp_stat_t          stat;
  logic [TIME_W-1:0] effLen;

  stepgen_ctrl #(.TIME_W(TIME_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .quadMode (outFmt == FMT_QUAD),
    .effLen   (effLen),
    .stat     (stat),
    .ctl      (ctl)
  );

  stepgen_dp #(
    .ACC_W (ACC_W),
    .TIME_W(TIME_W),
    .CNT_W (CNT_W),
    .PEND_W(PEND_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .rate     (rate),
    .stepLen  (stepLen),
    .stepSpace(stepSpace),
    .dirSetup (dirSetup),
    .dirHold  (dirHold),
    .outFmt   (outFmt),
    .ctl      (ctl),
    .stat     (stat),
    .effLen   (effLen),
    .pinA     (pinA),
    .pinB     (pinB),
    .stepCount(stepCount)
  );

endmodule

// File: rtl/stepgen_chk.sv
module stepgen_chk #(
  parameter int CNT_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic [1:0]              outFmt,
  input logic                    pinA,
  input logic                    pinB,
  input logic signed [CNT_W-1:0] stepCount
);

  p_pins_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && outFmt == 2'd0) |=> (!pinA || outFmt != 2'd0));

  p_count_frozen_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(stepCount));

  p_dir_steady_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (outFmt == 2'd0 && pinA) |=> (!pinA || outFmt != 2'd0 || $stable(pinB)));

  p_updown_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outFmt == 2'd1) |-> !(pinA && pinB));

  p_count_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pinA) && outFmt == 2'd0 && $past(outFmt) == 2'd0) |->
      (stepCount == (pinB ? $past(stepCount) + CNT_W'(1)
                          : $past(stepCount) - CNT_W'(1))));

  p_gray_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && outFmt == 2'd2 && $past(outFmt) == 2'd2) |->
      ($countones({pinA, pinB} ^ $past({pinA, pinB})) <= 1));

endmodule

bind step_pulse_gen stepgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .outFmt   (outFmt),
  .pinA     (pinA),
  .pinB     (pinB),
  .stepCount(stepCount)
);

// File: tb/step_pulse_gen_bench.sv
module step_pulse_gen_bench;

  localparam int CLK_P = 10;
  localparam logic signed [31:0] RATE_Q = 32'sh4000_0000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b0;
  logic signed [31:0] rate = '0;
  logic [15:0]        stepLen = 16'd1, stepSpace = 16'd1, dirSetup = 16'd1, dirHold = 16'd1;
  logic [1:0]         outFmt = 2'd0;
  logic               pinA, pinB;
  logic signed [31:0] stepCount;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_P/2) clk = ~clk;

  step_pulse_gen u_step_pulse_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate(rate),
    .stepLen(stepLen), .stepSpace(stepSpace), .dirSetup(dirSetup), .dirHold(dirHold),
    .outFmt(outFmt), .pinA(pinA), .pinB(pinB), .stepCount(stepCount)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pin monitor for format 0 timing
  bit monOn = 0;
  int expLen = 1, expSpace = 1, expSetup = 1, expHold = 1;
  bit prevA = 0, prevB = 1, prevSet = 0;
  int hiCnt = 0, loCnt = 1000, dirAge = 1000;
  int riseA = 0, riseB = 0;
  bit logOn = 0;
  logic [1:0] lastAB = 2'b00;
  logic [1:0] qLog [16];
  int logN = 0;

  always @(negedge clk) begin
    cycles++;
    if (prevSet) begin
      if (pinA && !prevA) riseA++;
      if (pinB && !prevB) riseB++;
    end
    if (monOn && prevSet) begin
      if (pinA && !prevA) begin
        chk(loCnt >= expSpace, "R4 step gap", loCnt, expSpace);
        chk(dirAge >= expSetup, "R5 dir setup", dirAge, expSetup);
      end
      if (!pinA && prevA) chk(hiCnt == expLen, "R3 pulse width", hiCnt, expLen);
      if (pinB != prevB) begin
        chk(!pinA && !prevA, "R5 dir moved in pulse", pinA, 0);
        chk(loCnt >= expHold, "R6 dir hold", loCnt, expHold);
      end
    end
    if (pinA && !prevA)      hiCnt = 1;
    else if (pinA)           hiCnt++;
    if (!pinA && prevA)      loCnt = 1;
    else if (!pinA)          loCnt++;
    if (pinB != prevB)       dirAge = 1;
    else                     dirAge++;
    prevA = pinA; prevB = pinB; prevSet = 1;
    if (logOn && {pinA, pinB} != lastAB && logN < 16) begin
      qLog[logN] = {pinA, pinB};
      logN++;
    end
    lastAB = {pinA, pinB};
  end

  function automatic int effv(input logic [15:0] w);
    return (w == 0) ? 1 : int'(w);
  endfunction

  task automatic setup_run(input logic [1:0] f, input int ln, sp, su, ho);
    @(negedge clk);
    enable = 1'b0;
    rate   = '0;
    @(negedge clk);
    outFmt = f; stepLen = 16'(ln); stepSpace = 16'(sp); dirSetup = 16'(su); dirHold = 16'(ho);
    expLen = effv(stepLen); expSpace = effv(stepSpace);
    expSetup = effv(dirSetup); expHold = effv(dirHold);
    enable = 1'b1;
  endtask

  task automatic drive(input logic signed [31:0] r, input int n);
    rate = r;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rate = '0;
  endtask

  task automatic t_reset;
    chk(pinA == 1'b0, "R1 pinA reset", pinA, 0);
    chk(pinB == 1'b1, "R1 pinB reset", pinB, 1);
    chk(stepCount == 0, "R1 count reset", stepCount, 0);
  endtask

  task automatic t_forward_backlog;
    longint base;
    monOn = 1;
    setup_run(2'd0, 3, 2, 1, 1);
    base = stepCount;
    rate = RATE_Q;
    repeat (400) @(posedge clk);
    @(negedge clk);
    rate = '0;
    chk(stepCount - base < 100, "R12 backlog lags", stepCount - base, 99);
    repeat (200) @(negedge clk);
    chk(stepCount - base == 100, "R2 R12 forward total", stepCount - base, 100);
  endtask

  task automatic t_reverse;
    longint base;
    setup_run(2'd0, 2, 1, 4, 3);
    base = stepCount;
    drive(-RATE_Q, 200);
    repeat (200) @(negedge clk);
    chk(stepCount - base == -50, "R11 reverse total", stepCount - base, -50);
    chk(pinB == 1'b0, "R5 dir reverse level", pinB, 0);
    drive(RATE_Q, 40);
    repeat (100) @(negedge clk);
    chk(stepCount - base == -40, "R11 back forward", stepCount - base, -40);
    chk(pinB == 1'b1, "R6 dir forward level", pinB, 1);
  endtask

  task automatic t_zero_words;
    longint base;
    setup_run(2'd0, 0, 0, 0, 0);
    base = stepCount;
    drive(RATE_Q, 100);
    drive(-RATE_Q, 20);
    repeat (60) @(negedge clk);
    chk(stepCount - base == 20, "R7 zero timing count", stepCount - base, 20);
    monOn = 0;
  endtask

  task automatic t_updown;
    setup_run(2'd1, 1, 1, 1, 1);
    riseA = 0; riseB = 0;
    drive(RATE_Q, 40);
    repeat (60) @(negedge clk);
    chk(riseA == 10, "R8 up pulses", riseA, 10);
    chk(riseB == 0, "R8 no down pulses", riseB, 0);
    riseA = 0; riseB = 0;
    drive(-RATE_Q, 40);
    repeat (60) @(negedge clk);
    chk(riseB == 10, "R8 down pulses", riseB, 10);
    chk(riseA == 0, "R8 no up pulses", riseA, 0);
  endtask

  task automatic t_quad;
    logic [1:0] fwdSeq [4];
    logic [1:0] revSeq [4];
    fwdSeq = '{2'b01, 2'b11, 2'b10, 2'b00};
    revSeq = '{2'b10, 2'b11, 2'b01, 2'b00};
    setup_run(2'd2, 2, 2, 1, 1);
    logN = 0; logOn = 1;
    drive(RATE_Q, 8);
    repeat (60) @(negedge clk);
    logOn = 0;
    chk(logN == 8, "R9 forward transitions", logN, 8);
    for (int i = 0; i < 8; i++)
      chk(qLog[i] == fwdSeq[i % 4], "R9 forward gray", qLog[i], fwdSeq[i % 4]);
    logN = 0; logOn = 1;
    drive(-RATE_Q, 8);
    repeat (60) @(negedge clk);
    logOn = 0;
    chk(logN == 8, "R9 reverse transitions", logN, 8);
    for (int i = 0; i < 8; i++)
      chk(qLog[i] == revSeq[i % 4], "R9 reverse gray", qLog[i], revSeq[i % 4]);
  endtask

  task automatic t_disable;
    longint base;
    int waitN = 0;
    setup_run(2'd0, 20, 1, 1, 1);
    rate = RATE_Q;
    while (!pinA && waitN < 100) begin
      @(negedge clk);
      waitN++;
    end
    chk(pinA == 1'b1, "R10 pulse reached", pinA, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(pinA == 1'b0, "R10 pulse cut", pinA, 0);
    base = stepCount;
    riseA = 0;
    repeat (30) @(negedge clk);
    chk(stepCount == base, "R10 count frozen", stepCount, base);
    chk(riseA == 0, "R10 no new pulses", riseA, 0);
    rate = '0;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward_backlog();
    t_reverse();
    t_zero_words();
    t_updown();
    t_quad();
    t_disable();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule